// File: doc/BRIEF.md
# Recirculating Longest-Prefix Lookup Engine

This block finds the longest-prefix match of a 32-bit IPv4 address in a three-level trie. The trie sits in one synchronous memory that the block reaches through a request port and a response port, and the memory may take any fixed number of cycles to answer. The first level is indexed by the upper 16 address bits. The second and third levels are each indexed by one further address byte, added to a child base pointer. Every table word is 17 bits wide. Bit 16 is the leaf flag, and bits 15:0 hold either the result value (for a leaf) or the child base pointer (for an internal node).

Many lookups share the single memory port. Each accepted address sends its first read and places a context entry in a recirculation queue. The entry holds the caller's token, the 16 address bits not yet used and the trie level. When an internal-node response returns, the entry passes through the queue again and a new read goes out. When a leaf response returns, the token and value are written to a registered result output. Results are tagged by token and can leave in a different order from their addresses. Putting them back in order is left to the consumer.

Top module: `lpm_circ_engine`

## Requirements
- R1: After a synchronous reset with no input offered, `res_valid` and `mem_req_valid` are low and `in_ready` is high.
- R2: An accepted address issues a memory read in the same cycle, and that read's index is address bits [31:16].
- R3: For an internal-node response (bit 16 clear), the next read index is the 16-bit pointer field plus the next unused address byte, modulo 2^16. The second read adds bits [15:8] and the third read adds bits [7:0].
- R4: A leaf response (bit 16 set) produces a result carrying the lookup's token and the word's bits 15:0. Lookups needing one, two or three reads all complete, and results of different lookups may leave out of order.
- R5: The response to a lookup's third read is treated as a leaf whatever its bit 16 holds. Its bits 15:0 become the result.
- R6: While an internal-node response is waiting to recirculate, `in_ready` is low, so recirculation wins over a new entry.
- R7: In a cycle where a leaf response exits, a new address can be accepted in that same cycle. This holds even when the recirculation queue is full.
- R8: With Q_DEPTH lookups in flight and nothing exiting, `in_ready` is low. At most one memory request is issued per cycle.
- R9: While `res_valid` is high and `res_ready` is low, the token and value stay stable. A leaf response that cannot be written out is not popped (`mem_rsp_ready` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Address offered |
| in_ready | output | 1 | Address accepted this cycle when valid |
| in_addr | input | 32 | IPv4 address to resolve |
| in_tok | input | TOK_W | Completion token returned with the result |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory can take a request |
| mem_req_addr | output | 16 | Table index to read |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_ready | output | 1 | Response consumed this cycle |
| mem_rsp_data | input | 17 | Table word: bit 16 leaf flag, bits 15:0 field |
| res_valid | output | 1 | Result valid (registered) |
| res_ready | input | 1 | Downstream takes the result |
| res_tok | output | TOK_W | Token of the finished lookup |
| res_val | output | 16 | Leaf value |

## Verification
The bench builds the engine with TOK_W = 4 and Q_DEPTH = 4. It attaches a memory model with a fixed latency of six cycles and an eight-entry response buffer. Because the queue is shallower than the memory latency, back-to-back entries fill the queue before the first response returns. This makes both the full-queue stall and the exit-with-entry case on a full queue reachable. A hand-built trie contains one-, two- and three-level paths, a pointer sum that wraps past 2^16, and a third-level word with its leaf flag clear.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int IP_W     = 32;
  localparam int IDX_W    = 16;
  localparam int STRIDE   = 8;
  localparam int REM_W    = IP_W - IDX_W;
  localparam int FIELD_W  = 16;
  localparam int WORD_W   = FIELD_W + 1;
  localparam int LEAF_BIT = FIELD_W;
  localparam int LVL_W    = 2;
  localparam logic [LVL_W-1:0] LAST_LVL = 2'd2;

  function automatic logic [IDX_W-1:0] child_index(
      input logic [FIELD_W-1:0] base,
      input logic [REM_W-1:0]   rem);
    return base + {{(IDX_W-STRIDE){1'b0}}, rem[REM_W-1 -: STRIDE]};
  endfunction
endpackage

// File: rtl/lpm_pipe_fifo.sv
module lpm_pipe_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enq,
  input  logic [W-1:0] enq_data,
  input  logic         deq,
  output logic [W-1:0] head,
  output logic         full,
  output logic         nonempty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (enq) store[wp] <= enq_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (enq) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (deq) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({enq, deq})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head     = store[rp];
  assign full     = (cnt == FULLC);
  assign nonempty = (cnt != '0);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    enq |-> (!full || deq));
  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    deq |-> nonempty);
endmodule

// File: rtl/lpm_step_ctrl.sv
module lpm_step_ctrl
  import lpm_pkg::*;
#(
  parameter int TOK_W = 4,
  localparam int ENT_W = TOK_W + REM_W + LVL_W
) (
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  input  logic [ENT_W-1:0]  head,
  input  logic              in_valid,
  input  logic [IP_W-1:0]   in_addr,
  input  logic [TOK_W-1:0]  in_tok,
  input  logic              req_ready,
  input  logic              q_full,
  input  logic              out_free,
  output logic              leaf_eff,
  output logic              enter_go,
  output logic              recirc_go,
  output logic              exit_go,
  output logic              in_ready,
  output logic              req_valid,
  output logic [IDX_W-1:0]  req_addr,
  output logic              rsp_ready,
  output logic              q_enq,
  output logic [ENT_W-1:0]  q_data,
  output logic              q_deq,
  output logic [TOK_W-1:0]  out_tok,
  output logic [FIELD_W-1:0] out_val
);
  logic [TOK_W-1:0]   h_tok;
  logic [REM_W-1:0]   h_rem;
  logic [LVL_W-1:0]   h_lvl;
  logic [FIELD_W-1:0] field;
  logic               node_pend;
  logic               q_room;

  assign {h_tok, h_rem, h_lvl} = head;
  assign field = rsp_data[FIELD_W-1:0];

  always_comb begin
    leaf_eff  = rsp_data[LEAF_BIT] || (h_lvl == LAST_LVL);
    node_pend = rsp_valid && !leaf_eff;
    exit_go   = rsp_valid && leaf_eff && out_free;
    recirc_go = node_pend && req_ready;
    q_room    = !q_full || exit_go;
    in_ready  = !node_pend && req_ready && q_room;
    enter_go  = in_valid && in_ready;
    req_valid = node_pend || (in_valid && q_room);
    req_addr  = node_pend ? child_index(field, h_rem)
                          : in_addr[IP_W-1 -: IDX_W];
    rsp_ready = exit_go || recirc_go;
    q_deq     = exit_go || recirc_go;
    q_enq     = enter_go || recirc_go;
    if (recirc_go)
      q_data = {h_tok, h_rem << STRIDE, LVL_W'(h_lvl + 1'b1)};
    else
      q_data = {in_tok, in_addr[REM_W-1:0], {LVL_W{1'b0}}};
    out_tok = h_tok;
    out_val = field;
  end
endmodule

// File: rtl/lpm_result_reg.sv
module lpm_result_reg #(
  parameter int TOK_W = 4,
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [TOK_W-1:0] ld_tok,
  input  logic [VAL_W-1:0] ld_val,
  input  logic             res_ready,
  output logic             res_valid,
  output logic [TOK_W-1:0] res_tok,
  output logic [VAL_W-1:0] res_val,
  output logic             free
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_tok   <= '0;
      res_val   <= '0;
    end else if (load) begin
      res_valid <= 1'b1;
      res_tok   <= ld_tok;
      res_val   <= ld_val;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  assign free = !res_valid || res_ready;

  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_tok) && $stable(res_val)));
endmodule

// File: rtl/lpm_circ_engine.sv
module lpm_circ_engine
  import lpm_pkg::*;
#(
  parameter int TOK_W   = 4,
  parameter int Q_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [IP_W-1:0]    in_addr,
  input  logic [TOK_W-1:0]   in_tok,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [IDX_W-1:0]   mem_req_addr,
  input  logic               mem_rsp_valid,
  output logic               mem_rsp_ready,
  input  logic [WORD_W-1:0]  mem_rsp_data,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [TOK_W-1:0]   res_tok,
  output logic [FIELD_W-1:0] res_val
);
  localparam int ENT_W = TOK_W + REM_W + LVL_W;

  logic [ENT_W-1:0]   q_head, q_data;
  logic               q_full, q_nonempty, q_enq, q_deq;
  logic               leaf_eff, enter_go, recirc_go, exit_go, out_free;
  logic [TOK_W-1:0]   out_tok;
  logic [FIELD_W-1:0] out_val;

  lpm_pipe_fifo #(.W(ENT_W), .DEPTH(Q_DEPTH)) u_queue (
    .clk(clk), .rst(rst), .enq(q_enq), .enq_data(q_data), .deq(q_deq),
    .head(q_head), .full(q_full), .nonempty(q_nonempty));

  lpm_step_ctrl #(.TOK_W(TOK_W)) u_ctrl (
    .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data), .head(q_head),
    .in_valid(in_valid), .in_addr(in_addr), .in_tok(in_tok),
    .req_ready(mem_req_ready), .q_full(q_full), .out_free(out_free),
    .leaf_eff(leaf_eff), .enter_go(enter_go), .recirc_go(recirc_go),
    .exit_go(exit_go), .in_ready(in_ready), .req_valid(mem_req_valid),
    .req_addr(mem_req_addr), .rsp_ready(mem_rsp_ready), .q_enq(q_enq),
    .q_data(q_data), .q_deq(q_deq), .out_tok(out_tok), .out_val(out_val));

  lpm_result_reg #(.TOK_W(TOK_W), .VAL_W(FIELD_W)) u_res (
    .clk(clk), .rst(rst), .load(exit_go), .ld_tok(out_tok), .ld_val(out_val),
    .res_ready(res_ready), .res_valid(res_valid), .res_tok(res_tok),
    .res_val(res_val), .free(out_free));

  // R2
  entry_read_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |->
      (mem_req_valid && mem_req_ready && mem_req_addr == in_addr[IP_W-1 -: IDX_W]));
  // R6
  recirc_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rsp_valid && !leaf_eff) |-> !in_ready);
  // R4
  rsp_paired_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rsp_valid && mem_rsp_ready) |-> q_nonempty);
  // R7
  concurrent_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rsp_valid && mem_rsp_ready && leaf_eff && mem_req_ready) |-> in_ready);
  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rsp_valid && leaf_eff && res_valid && !res_ready) |-> !mem_rsp_ready);
  // R8
  one_issue_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({enter_go, recirc_go}));
endmodule

// File: tb/lpm_circ_engine_test.sv
module lpm_circ_engine_test;
  localparam int CLK_P = 10;
  localparam int MLAT  = 6;
  localparam int RCAP  = 8;
  localparam int NV    = 10;

  // {address, expected value}
  localparam logic [47:0] VEC [NV] = '{
    {32'h07070000, 16'h5D5D}, {32'h0A123300, 16'h1133},
    {32'h0A12C805, 16'h2205}, {32'h0A12C8FF, 16'h22FF},
    {32'h0B001122, 16'h4422}, {32'h0C002000, 16'h5A4A},
    {32'h0C000500, 16'hA5AF}, {32'hFFFF1234, 16'hA5A5},
    {32'h0A120000, 16'h1100}, {32'h12345678, 16'h486E}};

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_ready;
  logic [31:0] in_addr = '0;
  logic [3:0]  in_tok = '0;
  logic mem_req_valid, mem_req_ready, mem_rsp_valid, mem_rsp_ready;
  logic [15:0] mem_req_addr;
  logic [16:0] mem_rsp_data;
  logic res_valid, res_ready = 1;
  logic [3:0]  res_tok;
  logic [15:0] res_val;

  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  lpm_circ_engine #(.TOK_W(4), .Q_DEPTH(4)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_tok(in_tok), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_tok(res_tok), .res_val(res_val));

  function automatic logic [16:0] mem_word(input logic [15:0] a);
    if (a == 16'h0A12) return {1'b0, 16'h1000};
    if (a == 16'h0B00) return {1'b0, 16'h3000};
    if (a == 16'h0C00) return {1'b0, 16'hFFF0};
    case (a[15:8])
      8'h10: return (a[7:0] == 8'hC8) ? {1'b0, 16'h2000} : {1'b1, 16'h1100 + {8'h0, a[7:0]}};
      8'h20: return {1'b1, 16'h2200 + {8'h0, a[7:0]}};
      8'h30: return {1'b0, 16'h4000};
      8'h40: return {1'b0, 16'h4400 + {8'h0, a[7:0]}};
      default: return {1'b1, a ^ 16'h5A5A};
    endcase
  endfunction

  // memory model: fixed latency, in-order response buffer
  logic [MLAT-1:0] pv = '0;
  logic [16:0] pd [MLAT];
  logic [16:0] rq [RCAP];
  logic [2:0]  rh = '0, rt = '0;
  int rc = 0;
  assign mem_req_ready = ($countones(pv) + rc) < RCAP;
  assign mem_rsp_valid = (rc != 0);
  assign mem_rsp_data  = rq[rh];

  always @(posedge clk) begin
    pv <= {pv[MLAT-2:0], mem_req_valid && mem_req_ready};
    pd[0] <= mem_word(mem_req_addr);
    for (int i = 1; i < MLAT; i++) pd[i] <= pd[i-1];
    if (pv[MLAT-1]) begin rq[rt] <= pd[MLAT-1]; rt <= rt + 1'b1; end
    if (mem_rsp_valid && mem_rsp_ready) rh <= rh + 1'b1;
    rc <= rc + int'(pv[MLAT-1]) - int'(mem_rsp_valid && mem_rsp_ready);
  end

  // monitors
  logic [15:0] got_v [16];
  logic [15:0] req_log [64];
  int n_res = 0, n_req = 0, conc = 0, prio_obs = 0, prio_bad = 0;
  always @(posedge clk) begin
    if (res_valid && res_ready) begin got_v[res_tok] <= res_val; n_res <= n_res + 1; end
    if (mem_req_valid && mem_req_ready) begin req_log[n_req[5:0]] <= mem_req_addr; n_req <= n_req + 1; end
    if (in_valid && in_ready && mem_rsp_valid && mem_rsp_ready) conc <= conc + 1;
    if (mem_rsp_valid && !mem_rsp_data[16] && mem_rsp_data[15:8] != 8'h44 && in_valid) begin
      prio_obs <= prio_obs + 1;
      if (in_ready) prio_bad <= prio_bad + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic [3:0] t);
    @(negedge clk);
    in_valid = 1; in_addr = a; in_tok = t;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk); in_valid = 0;
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base, acc;
    logic [15:0] hv;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1 reset state
    chk(!res_valid, "R1 res_valid", res_valid, 0);
    chk(!mem_req_valid, "R1 mem_req_valid", mem_req_valid, 0);
    chk(in_ready, "R1 in_ready", in_ready, 1);

    // R2, R3: isolated three-level lookup
    base = n_req;
    send(32'h0A12C805, 4'd10);
    idle(40);
    chk(n_req - base == 3, "R3 read count", n_req - base, 3);
    chk(req_log[base[5:0]] == 16'h0A12, "R2 first index", req_log[base[5:0]], 16'h0A12);
    chk(req_log[6'(base+1)] == 16'h10C8, "R3 second index", req_log[6'(base+1)], 16'h10C8);
    chk(req_log[6'(base+2)] == 16'h2005, "R3 third index", req_log[6'(base+2)], 16'h2005);
    chk(got_v[10] == 16'h2205, "R4 three-read result", got_v[10], 16'h2205);

    // R5: third-level word with leaf flag clear
    base = n_req;
    send(32'h0B001122, 4'd11);
    idle(40);
    chk(n_req - base == 3, "R5 read count", n_req - base, 3);
    chk(req_log[6'(base+2)] == 16'h4022, "R3 level-three index", req_log[6'(base+2)], 16'h4022);
    chk(got_v[11] == 16'h4422, "R5 forced leaf value", got_v[11], 16'h4422);

    // R4: vector table, back to back
    base = n_res;
    for (int i = 0; i < NV; i++) send(VEC[i][47:16], 4'(i));
    idle(80);
    chk(n_res - base == NV, "R4 result count", n_res - base, NV);
    for (int i = 0; i < NV; i++)
      chk(got_v[i] == VEC[i][15:0], "R4 vector value", got_v[i], VEC[i][15:0]);
    // R6: recirculation precedes entry
    chk(prio_obs > 0, "R6 pending node seen", prio_obs, 1);
    chk(prio_bad == 0, "R6 entry during pending node", prio_bad, 0);

    // R9: output backpressure
    @(negedge clk); res_ready = 0;
    send(32'h07070000, 4'd12);
    idle(14);
    chk(res_valid && res_tok == 4'd12, "R9 result held tok", res_tok, 12);
    hv = res_val;
    idle(3);
    chk(res_val == hv && res_val == 16'h5D5D, "R9 value stable", res_val, 16'h5D5D);
    send(32'h12345678, 4'd13);
    idle(14);
    chk(mem_rsp_valid && !mem_rsp_ready, "R9 response not popped", {mem_rsp_valid, mem_rsp_ready}, 2'b10);
    chk(res_tok == 4'd12, "R9 old result kept", res_tok, 12);
    @(negedge clk); res_ready = 1;
    idle(6);
    chk(got_v[12] == 16'h5D5D, "R9 first drained", got_v[12], 16'h5D5D);
    chk(got_v[13] == 16'h486E, "R9 second drained", got_v[13], 16'h486E);

    // R7, R8: fill the queue, then exit with entry
    base = n_res; acc = 0;
    @(negedge clk);
    in_valid = 1; in_addr = 32'h07070000; in_tok = 4'd15;
    for (int k = 0; k < 12; k++) begin
      #1;
      if (k == 4) chk(!in_ready, "R8 full queue stalls entry", in_ready, 0);
      if (k == 7) chk(in_ready && mem_rsp_ready, "R7 exit with entry on full queue",
                      {in_ready, mem_rsp_ready}, 2'b11);
      if (in_ready) acc++;
      @(negedge clk);
    end
    in_valid = 0;
    idle(30);
    chk(n_res - base == acc, "R8 all admitted complete", n_res - base, acc);
    chk(conc > 0, "R7 concurrent exit and entry", conc, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule